// File: doc/BRIEF.md
# Serial Bit Stuffing Codec with Bit Monitor

This block sits between a frame sequencer and the bus transceiver of a serial node whose bus has a dominant and a recessive level. On the transmit side it takes one bit per bit strobe from an upstream source. While the stuffing window is open, after a run of `RUN_LEN` equal bits it launches one bit of the opposite level. During that inserted bit it holds the upstream source with a ready signal. Every launched level is held on the line for the whole bit time.

On the receive side the sampled bus level is taken at each bit strobe. Inserted bits are removed, and every other bit is passed on with a one-cycle valid pulse. A sixth equal level where an inserted bit was due is reported as a stuff error. A monitor compares the level this node launched for a bit with the level sampled at the end of that bit and flags a bit error. Bits launched recessive and seen dominant are exempt while the sequencer marks them as arbitration, ACK slot or passive error flag. The sequencer drives the window and the exemption flags per field. Checksum and framing belong to the sequencer.

Top module: `bitstuff_codec`

## Requirements
- R1: After reset `tx_line` is recessive (1), `tx_ready` is 1, and `rx_valid`, `stuff_err` and `bit_err` are 0. Level encoding with the default parameters: dominant = 0, recessive = 1.
- R2: With `tx_on` and `stuff_en` high, after `RUN_LEN` (default 5) consecutive equal bits accepted from `tx_bit`, `tx_ready` is 0 before the next strobe. At that strobe `tx_line` takes the opposite level and `tx_bit` is not consumed. `tx_line` changes only in the clock after a strobe.
- R3: An inserted bit counts as the first bit of the following run, so four more bits of its level trigger the next insertion. Two successive strobes never both insert.
- R4: While `stuff_en` is low, any number of equal bits pass unaltered on transmit, and on receive each is delivered with no stuff error.
- R5: The run count restarts when the window opens: equal bits launched while `stuff_en` was low do not count toward an insertion.
- R6: An insertion that became due on the last bit inside the window is still launched at the next strobe, even if `stuff_en` is low there.
- R7: A strobe with `tx_on` low drives `tx_line` recessive, clears any pending insertion and leaves `tx_ready` high.
- R8: Each received bit that is not an inserted bit appears on `rx_data` with a one-clock `rx_valid` pulse in the clock after its strobe. An inserted bit produces no pulse. No output pulse occurs without a strobe in the clock before it.
- R9: When an inserted bit is due on receive and the sampled level equals the previous run, `stuff_err` pulses in the clock after that strobe, and `rx_valid` stays low there.
- R10: When `tx_on` was high at the strobe that launched a bit, and the level sampled at the following strobe differs from it, `bit_err` pulses in the clock after that following strobe.
- R11: A bit launched recessive and sampled dominant raises no bit error when `arb_fld`, `ack_slot` or `psv_flag` was high at its launch strobe. A bit launched dominant and sampled recessive is an error regardless of these flags.
- R12: A bit launched with `tx_on` low never raises a bit error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | One-clock pulse at each bit boundary / sample point |
| tx_on | input | 1 | Node transmits the bit launched at this strobe |
| stuff_en | input | 1 | Stuffing window open for this bit |
| tx_bit | input | 1 | Next bit from the upstream source, consumed when `tx_ready` is high at a strobe |
| tx_ready | output | 1 | Upstream bit will be consumed at the next strobe |
| tx_line | output | 1 | Level driven to the transceiver, held per bit time |
| rx_bit | input | 1 | Bus level sampled at this strobe |
| arb_fld | input | 1 | Bit launched at this strobe lies in the arbitration field |
| ack_slot | input | 1 | Bit launched at this strobe is the ACK slot |
| psv_flag | input | 1 | Bit launched at this strobe belongs to a passive error flag |
| rx_data | output | 1 | Destuffed received bit |
| rx_valid | output | 1 | `rx_data` holds a new bit |
| stuff_err | output | 1 | Stuff rule violated on receive |
| bit_err | output | 1 | Sent and monitored level disagree |

## Verification
The transmit path is driven with runs of ones, then runs of zeros, so that an insertion cannot be confused with a data change. A long run with the window closed shows the window gating. A run that starts as the window opens separates a restarted count from one carried over. A run that ends exactly at the window close tests the insertion still owed. The receive path gets a run that carries a proper inserted bit and a run that breaks the rule, which separates removal from error reporting. The monitor sees each combination of sent and sampled level, with and without each exemption flag and with transmission off, to show which mismatches count.

// File: rtl/bitstuff_pkg.sv
package bitstuff_pkg;

   // tag stored with each launched bit, consumed one strobe later by the monitor
   typedef struct packed {
      logic active;   // node drove this bit
      logic exempt;   // recessive-sent / dominant-seen tolerated
   } bs_tag_t;

   function automatic int unsigned bs_cnt_width(input int unsigned run_len);
      return $clog2(run_len + 1);
   endfunction

endpackage

// File: rtl/bs_stuff_enc.sv
module bs_stuff_enc #(
   parameter int unsigned RUN_LEN = 5,
   parameter bit          REC     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb,
   input  logic tx_on,
   input  logic win,
   input  logic din,
   output logic ready,
   output logic line
);
   localparam int unsigned CW = bitstuff_pkg::bs_cnt_width(RUN_LEN);
   localparam logic [CW-1:0] LAST_CNT = CW'(RUN_LEN - 1);

   logic [CW-1:0] run_q;
   logic          last_q;
   logic          pend_q;
   logic          line_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= '0;
         last_q <= REC;
         pend_q <= 1'b0;
         line_q <= REC;
      end else if (stb) begin
         if (!tx_on) begin
            line_q <= REC;
            run_q  <= '0;
            pend_q <= 1'b0;
         end else if (pend_q) begin
            // owed complement, also first bit of the next run
            line_q <= ~last_q;
            last_q <= ~last_q;
            run_q  <= CW'(1);
            pend_q <= 1'b0;
         end else begin
            line_q <= din;
            last_q <= din;
            if (!win) begin
               run_q <= '0;
            end else if (run_q != '0 && din == last_q) begin
               run_q <= run_q + 1'b1;
               if (run_q == LAST_CNT) pend_q <= 1'b1;
            end else begin
               run_q <= CW'(1);
            end
         end
      end
   end

   assign ready = ~pend_q;
   assign line  = line_q;

endmodule

// File: rtl/bs_stuff_dec.sv
module bs_stuff_dec #(
   parameter int unsigned RUN_LEN = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb,
   input  logic win,
   input  logic rx,
   output logic dout,
   output logic dvalid,
   output logic serr
);
   localparam int unsigned CW = bitstuff_pkg::bs_cnt_width(RUN_LEN);
   localparam logic [CW-1:0] LAST_CNT = CW'(RUN_LEN - 1);

   logic [CW-1:0] run_q;
   logic          last_q;
   logic          due_q;
   logic          dout_q;
   logic          dvalid_q;
   logic          serr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q    <= '0;
         last_q   <= 1'b0;
         due_q    <= 1'b0;
         dout_q   <= 1'b0;
         dvalid_q <= 1'b0;
         serr_q   <= 1'b0;
      end else begin
         dvalid_q <= 1'b0;
         serr_q   <= 1'b0;
         if (stb) begin
            if (due_q) begin
               due_q <= 1'b0;
               if (rx == last_q) begin
                  serr_q <= 1'b1;
                  run_q  <= '0;
               end else begin
                  run_q  <= CW'(1);
                  last_q <= rx;
               end
            end else begin
               dvalid_q <= 1'b1;
               dout_q   <= rx;
               last_q   <= rx;
               if (!win) begin
                  run_q <= '0;
               end else if (run_q != '0 && rx == last_q) begin
                  run_q <= run_q + 1'b1;
                  if (run_q == LAST_CNT) due_q <= 1'b1;
               end else begin
                  run_q <= CW'(1);
               end
            end
         end
      end
   end

   assign dout   = dout_q;
   assign dvalid = dvalid_q;
   assign serr   = serr_q;

endmodule

// File: rtl/bs_bit_mon.sv
module bs_bit_mon #(
   parameter bit REC = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb,
   input  logic tx_on,
   input  logic exempt_in,
   input  logic sent,
   input  logic seen,
   output logic berr
);
   import bitstuff_pkg::*;

   bs_tag_t tag_q;
   logic    berr_q;
   logic    mism;
   logic    tolerated;

   always_comb begin
      mism      = (sent != seen);
      tolerated = tag_q.exempt && (sent == REC) && (seen != REC);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tag_q  <= '0;
         berr_q <= 1'b0;
      end else begin
         berr_q <= 1'b0;
         if (stb) begin
            berr_q       <= tag_q.active && mism && !tolerated;
            tag_q.active <= tx_on;
            tag_q.exempt <= exempt_in;
         end
      end
   end

   assign berr = berr_q;

endmodule

// File: rtl/bitstuff_codec.sv
module bitstuff_codec #(
   parameter int unsigned RUN_LEN = 5,
   parameter bit          DOM_LVL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_stb,
   input  logic tx_on,
   input  logic stuff_en,
   input  logic tx_bit,
   output logic tx_ready,
   output logic tx_line,
   input  logic rx_bit,
   input  logic arb_fld,
   input  logic ack_slot,
   input  logic psv_flag,
   output logic rx_data,
   output logic rx_valid,
   output logic stuff_err,
   output logic bit_err
);
   localparam bit REC = ~DOM_LVL;

   generate
      if (RUN_LEN < 2 || RUN_LEN > 31) begin : g_bad_run
         $error("bitstuff_codec: RUN_LEN must lie in 2..31");
      end
   endgenerate

   logic line_w;
   logic exempt_w;

   assign exempt_w = arb_fld | ack_slot | psv_flag;

   bs_stuff_enc #(.RUN_LEN(RUN_LEN), .REC(REC)) enc_i (
      .clk   (clk),
      .rst_n (rst_n),
      .stb   (bit_stb),
      .tx_on (tx_on),
      .win   (stuff_en),
      .din   (tx_bit),
      .ready (tx_ready),
      .line  (line_w)
   );

   bs_stuff_dec #(.RUN_LEN(RUN_LEN)) dec_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .stb    (bit_stb),
      .win    (stuff_en),
      .rx     (rx_bit),
      .dout   (rx_data),
      .dvalid (rx_valid),
      .serr   (stuff_err)
   );

   bs_bit_mon #(.REC(REC)) mon_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .stb       (bit_stb),
      .tx_on     (tx_on),
      .exempt_in (exempt_w),
      .sent      (line_w),
      .seen      (rx_bit),
      .berr      (bit_err)
   );

   assign tx_line = line_w;

endmodule

// File: rtl/bitstuff_codec_chk.sv
module bitstuff_codec_chk #(
   parameter bit DOM_LVL = 1'b0
) (
   input logic clk,
   input logic rst_n,
   input logic bit_stb,
   input logic tx_on,
   input logic tx_ready,
   input logic tx_line,
   input logic rx_valid,
   input logic stuff_err,
   input logic bit_err
);
   logic ins_prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) ins_prev_q <= 1'b0;
      else if (bit_stb) ins_prev_q <= tx_on && !tx_ready;
   end

   a_r2_nrz_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_stb |=> $stable(tx_line));

   a_r2_insert_inverts: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb && tx_on && !tx_ready) |=> (tx_line != $past(tx_line)));

   a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb && ins_prev_q) |-> tx_ready);

   a_r7_off_recessive: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb && !tx_on) |=> (tx_line == ~DOM_LVL) && tx_ready);

   a_r8_pulse_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid || stuff_err || bit_err) |-> $past(bit_stb));

   a_r9_err_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_valid && stuff_err));

endmodule

bind bitstuff_codec bitstuff_codec_chk #(.DOM_LVL(DOM_LVL)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bit_stb   (bit_stb),
   .tx_on     (tx_on),
   .tx_ready  (tx_ready),
   .tx_line   (tx_line),
   .rx_valid  (rx_valid),
   .stuff_err (stuff_err),
   .bit_err   (bit_err)
);

// File: tb/bitstuff_codec_tb_top.sv
`timescale 1ns/1ps
module bitstuff_codec_tb_top;

   logic clk = 1'b0;
   logic rst_n;
   logic bit_stb, tx_on, stuff_en, tx_bit, rx_bit, arb_fld, ack_slot, psv_flag;
   logic tx_ready, tx_line, rx_data, rx_valid, stuff_err, bit_err;

   int n_chk  = 0;
   int n_fail = 0;
   logic rdy_before;

   always #2.5 clk = ~clk;

   bitstuff_codec #(.RUN_LEN(5), .DOM_LVL(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .tx_on(tx_on),
      .stuff_en(stuff_en), .tx_bit(tx_bit), .tx_ready(tx_ready),
      .tx_line(tx_line), .rx_bit(rx_bit), .arb_fld(arb_fld),
      .ack_slot(ack_slot), .psv_flag(psv_flag), .rx_data(rx_data),
      .rx_valid(rx_valid), .stuff_err(stuff_err), .bit_err(bit_err)
   );

   // transmit table, fields {tx_on, stuff_en, tx_bit, expected ready before strobe, expected line after}
   localparam logic [4:0] TXV [0:32] = '{
      5'b11111, 5'b11111, 5'b11111, 5'b11111, 5'b11111,   // R2 five ones
      5'b11000,                                          // R2 inserted zero
      5'b11010, 5'b11010, 5'b11010, 5'b11010,            // R3 four zeros after insert
      5'b11101,                                          // R3 inserted one
      5'b11111,
      5'b10010, 5'b10010, 5'b10010, 5'b10010, 5'b10010, 5'b10010, 5'b10010, // R4 window closed
      5'b11010, 5'b11010, 5'b11010, 5'b11010, 5'b11010,  // R5 count restarts
      5'b11001,                                          // R5 insert after five in window
      5'b11111, 5'b11111, 5'b11111, 5'b11111,            // run reaches five at window end
      5'b10000,                                          // R6 owed insert outside window
      5'b10010,
      5'b00011, 5'b00011                                 // R7 transmitter off
   };

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; bit_stb = 1'b0; tx_on = 1'b0; stuff_en = 1'b0; tx_bit = 1'b1;
      rx_bit = 1'b1; arb_fld = 1'b0; ack_slot = 1'b0; psv_flag = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // one bit time: inputs at a falling edge, strobe for one clock, sample at next falling edge
   task automatic step(input logic on, input logic en, input logic din, input logic rx,
                       input logic a, input logic k, input logic p);
      rdy_before = tx_ready;
      tx_on = on; stuff_en = en; tx_bit = din; rx_bit = rx;
      arb_fld = a; ack_slot = k; psv_flag = p; bit_stb = 1'b1;
      @(negedge clk);
      bit_stb = 1'b0;
   endtask

   task automatic idle();
      @(negedge clk);
   endtask

   initial begin
      #1000000;
      n_fail++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      do_reset();
      // R1 reset state
      check("R1 tx_line", tx_line, 1'b1);
      check("R1 tx_ready", tx_ready, 1'b1);
      check("R1 rx_valid", rx_valid, 1'b0);
      check("R1 stuff_err", stuff_err, 1'b0);
      check("R1 bit_err", bit_err, 1'b0);

      // transmit table with loopback, no bit errors expected
      for (int i = 0; i < 33; i++) begin
         step(TXV[i][4], TXV[i][3], TXV[i][2], tx_line, 1'b0, 1'b0, 1'b0);
         check($sformatf("R2-table row %0d ready", i), rdy_before, TXV[i][1]);
         check($sformatf("R2-table row %0d line", i), tx_line, TXV[i][0]);
         check($sformatf("R10 loopback row %0d bit_err", i), bit_err, 1'b0);
         idle();
      end

      // R8 receive with a proper inserted bit, R4 window closed
      do_reset();
      for (int i = 0; i < 5; i++) begin
         step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
         check("R8 data valid", rx_valid, 1'b1);
         check("R8 data value", rx_data, 1'b0);
         idle();
      end
      step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      check("R8 inserted bit dropped", rx_valid, 1'b0);
      check("R8 inserted bit no error", stuff_err, 1'b0);
      idle();
      step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      check("R8 after insert valid", rx_valid, 1'b1);
      check("R8 after insert data", rx_data, 1'b1);
      idle();
      step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      check("R8 next data", rx_data, 1'b0);
      idle();
      for (int i = 0; i < 7; i++) begin
         step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
         check("R4 rx window closed valid", rx_valid, 1'b1);
         check("R4 rx window closed no stuff_err", stuff_err, 1'b0);
         idle();
      end
      check("R8 no pulse without strobe", rx_valid, 1'b0);

      // R9 sixth equal bit
      do_reset();
      for (int i = 0; i < 5; i++) begin
         step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
         idle();
      end
      step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      check("R9 stuff_err", stuff_err, 1'b1);
      check("R9 no valid", rx_valid, 1'b0);
      idle();
      check("R9 single pulse", stuff_err, 1'b0);

      // R10-R12 bit monitor, window closed
      do_reset();
      step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);            // launch dominant
      check("R12 first bit after reset", bit_err, 1'b0);
      idle();
      step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);            // seen rec, launch rec with arb
      check("R10 dominant sent recessive seen", bit_err, 1'b1);
      idle();
      step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);            // arb exempt, launch rec with ack
      check("R11 arbitration exempt", bit_err, 1'b0);
      idle();
      step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);            // ack exempt, launch rec with passive flag
      check("R11 ack slot exempt", bit_err, 1'b0);
      idle();
      step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);            // passive exempt, launch rec no flag
      check("R11 passive flag exempt", bit_err, 1'b0);
      idle();
      step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);            // error, launch dom with arb
      check("R10 recessive sent dominant seen", bit_err, 1'b1);
      idle();
      step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);            // dom sent rec seen, flags no help
      check("R11 dominant never exempt", bit_err, 1'b1);
      idle();
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);            // bit launched with tx_on low
      check("R12 not transmitting", bit_err, 1'b0);
      check("R7 line recessive when off", tx_line, 1'b1);
      idle();

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule